// File: doc/BRIEF.md
# Management PHY Register File with Timed Autonegotiation

This block is the host-facing management side of an Ethernet PHY. A single 32-bit command word carries an operation, a 5-bit register address and 16 bits of data into an array of 32 sixteen-bit PHY registers. Each address has a fixed capability: read, write, both, or neither. One clock edge after a command is written, the command word can be read back. It then holds the ready flag, the read data or the echoed write data, and an error flag when the access was not allowed. If the command asked for it, a one-cycle completion interrupt pulse also appears.

The block models autonegotiation with a counter. A control-register write that sets both the enable bit and the restart bit takes the link down and clears the negotiation-done flag. A delay of `ANEG_CYCLES` clocks then starts, and when it ends the link and the done flag come back together. The PHY status link bit and a MAC-side link-up output always move together. They are also driven by edges on an external link input, and that input is applied after reset. The control register drives the loopback select, the speed code and the duplex outputs for the transmit path.

Top module: `mgmt_phy_regs`

## Requirements
- R1: After reset with `link_ext_up` high, `mac_link_up` is 1, `cmd_irq` is 0 and `cmd_rdata` is 0. The control register (address 0) holds 0x1140 and the status register (address 1) holds 0x794d. The status link bit is bit 2 and the negotiation-done bit is bit 5. Other reset values: address 2 = 0x0141, 3 = 0x0cc2, 4 = 0x0de1, 5 = 0x01e0, 9 = 0x0e00, 10 = 0x3c00, 16 = 0x0360, 17 = 0xac00, 20 = 0x0d60, all others 0.
- R2: When `link_ext_up` is low during reset, the status register resets to 0x7949 and `mac_link_up` resets to 0.
- R3: A write to address 0 whose data has both bit 12 (enable) and bit 9 (restart) set does three things one edge later: it stores the data, it clears status bit 2 and bit 5, and it drives `mac_link_up` to 0. Any pending delay is cancelled and a new delay of `ANEG_CYCLES` clocks starts.
- R4: If a restart is written at edge k and no new restart follows, `mac_link_up` stays 0 after edges k+1 to k+N-1, where N is `ANEG_CYCLES`. After edge k+N it is 1, with status bits 2 and 5 both set (0x796d from the reset value).
- R5: A restart while the delay is running reloads the full count, so the link returns N edges after the last restart.
- R6: Writable addresses are 0, 4, 9, 16 and 20. A write to any other address leaves the register unchanged and sets the error flag, bit 30, of the command word.
- R7: Readable addresses are the writable ones plus 1, 2, 3, 5, 10 and 17. A read (op 10) returns the register value in bits 15:0 without error. A read of any other address sets bit 30 and echoes the written data.
- R8: The command word has this layout: data in bits 15:0, address in bits 20:16, op in bits 27:26 (01 write, 10 read, 00 and 11 no access), ready in bit 28, interrupt enable in bit 29 and error in bit 30. Bits 31 and 25:21 read as 0. After every command, `cmd_rdata` shows ready = 1 with the op, address and enable echoed.
- R9: `cmd_irq` is high for exactly the one cycle after a command whose bit 29 was set, and it stays low for commands without it.
- R10: `loopback_en` equals control register bit 14.
- R11: `speed_mode` is {control bit 6, control bit 13}: 10 means 1000 Mb/s, 01 means 100 Mb/s and 00 means 10 Mb/s. `full_duplex` equals control bit 8.
- R12: A falling edge on `link_ext_up` clears both status bit 2 and `mac_link_up`. A rising edge sets both. The two always agree.
- R13: A control write that sets only one of bit 12 and bit 9 has no effect on the link or on the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ext_up | input | 1 | External link state, edge-applied |
| cmd_wr | input | 1 | Command strobe |
| cmd_wdata | input | 32 | Command word from the host |
| cmd_rdata | output | 32 | Completed command word |
| cmd_irq | output | 1 | Completion interrupt pulse |
| mac_link_up | output | 1 | MAC-side link-up status bit |
| loopback_en | output | 1 | Route transmit back to receive |
| speed_mode | output | 2 | Speed code from the control register |
| full_duplex | output | 1 | Duplex select |

## Verification
Every command result, the interrupt pulse and the loopback, speed and duplex outputs are registered, so each is due exactly one edge after the command is sampled. Reads return the register contents from before that edge. A link change from a restart or from the external input is also visible after one edge. The link recovery is due N edges after the last restart, and the bench checks that it has not happened at edge N-1 and has happened at edge N. The bench drives and compares on the falling clock edge against a behavioural model that is stepped once per cycle in the same order, so every compare lands on the cycle in which the result is due.

// File: rtl/mphy_pkg.sv
package mphy_pkg;

   localparam int unsigned CMD_W    = 32;
   localparam int unsigned FIELD_W  = 16;
   localparam int unsigned AFIELD_W = 5;

   // command word fields
   localparam int unsigned CMD_ADDR_LO = 16;
   localparam int unsigned CMD_OP_LO   = 26;
   localparam int unsigned CMD_RDY     = 28;
   localparam int unsigned CMD_IE      = 29;
   localparam int unsigned CMD_ERR     = 30;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_SPARE = 2'b11
   } mphy_op_e;

   // register indices with behaviour attached
   localparam int unsigned CTRL_IDX = 0;
   localparam int unsigned STAT_IDX = 1;

   // control bits
   localparam int unsigned CB_SPD_HI  = 6;
   localparam int unsigned CB_FDX     = 8;
   localparam int unsigned CB_RESTART = 9;
   localparam int unsigned CB_ANEG    = 12;
   localparam int unsigned CB_SPD_LO  = 13;
   localparam int unsigned CB_LOOP    = 14;

   // status bits
   localparam int unsigned SB_LINK = 2;
   localparam int unsigned SB_DONE = 5;

   // capability: bit1 = writable, bit0 = readable
   function automatic logic [1:0] reg_cap(input int unsigned idx);
      case (idx)
         0, 4, 9, 16, 20:   reg_cap = 2'b11;
         1, 2, 3, 5, 10, 17: reg_cap = 2'b01;
         default:           reg_cap = 2'b00;
      endcase
   endfunction

   function automatic logic [FIELD_W-1:0] reg_init(input int unsigned idx);
      case (idx)
         0:       reg_init = 16'h1140;
         1:       reg_init = 16'h794d;
         2:       reg_init = 16'h0141;
         3:       reg_init = 16'h0cc2;
         4:       reg_init = 16'h0de1;
         5:       reg_init = 16'h01e0;
         9:       reg_init = 16'h0e00;
         10:      reg_init = 16'h3c00;
         16:      reg_init = 16'h0360;
         17:      reg_init = 16'hac00;
         20:      reg_init = 16'h0d60;
         default: reg_init = 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/mphy_aneg_timer.sv
module mphy_aneg_timer #(
   parameter int unsigned ANEG_CYCLES = 50_000_000,
   localparam int unsigned CNT_W = $clog2(ANEG_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic expire,
   output logic busy
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= CNT_W'(ANEG_CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expire = (cnt_q == CNT_W'(1));
   assign busy   = (cnt_q != '0);

   // R4: expiry is a single event per delay
   a_r4_single_expire: assert property (@(posedge clk) disable iff (rst)
      expire && !restart |=> !expire);

   // R5: a restart always leaves the timer running
   a_r5_restart_busy: assert property (@(posedge clk) disable iff (rst)
      restart |=> busy);

endmodule

// File: rtl/mphy_regfile.sv
module mphy_regfile
   import mphy_pkg::*;
#(
   parameter int unsigned NREGS = 32,
   parameter int unsigned REG_W = 16,
   localparam int unsigned ADDR_W = AFIELD_W,
   localparam int unsigned SPACE  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              link_ext_up,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              aneg_expire,
   output logic              aneg_restart,
   output logic [REG_W-1:0]  ctrl_q,
   output logic              mac_link_up
);

   logic [REG_W-1:0] regs [SPACE];
   logic [REG_W-1:0] stat_q, stat_d;
   logic             mac_q, mac_d;
   logic             ext_q;
   logic             ext_rise, ext_fall;

   assign aneg_restart = wr_en && (wr_addr == ADDR_W'(CTRL_IDX))
                         && wr_data[CB_ANEG] && wr_data[CB_RESTART];

   assign ext_rise = link_ext_up && !ext_q;
   assign ext_fall = !link_ext_up && ext_q;

   // later events override earlier ones: external edge, expiry, restart
   always_comb begin
      stat_d = stat_q;
      mac_d  = mac_q;
      if (ext_rise) begin
         stat_d[SB_LINK] = 1'b1;
         mac_d           = 1'b1;
      end else if (ext_fall) begin
         stat_d[SB_LINK] = 1'b0;
         mac_d           = 1'b0;
      end
      if (aneg_expire) begin
         stat_d[SB_LINK] = 1'b1;
         stat_d[SB_DONE] = 1'b1;
         mac_d           = 1'b1;
      end
      if (aneg_restart) begin
         stat_d[SB_LINK] = 1'b0;
         stat_d[SB_DONE] = 1'b0;
         mac_d           = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q          <= reg_init(STAT_IDX);
         stat_q[SB_LINK] <= link_ext_up;
         mac_q           <= link_ext_up;
         ext_q           <= link_ext_up;
      end else begin
         stat_q <= stat_d;
         mac_q  <= mac_d;
         ext_q  <= link_ext_up;
      end
   end

   for (genvar i = 0; i < SPACE; i++) begin : g_reg
      localparam logic [1:0] CAP = reg_cap(i);
      if (i == STAT_IDX) begin : g_stat
         assign regs[i] = stat_q;
      end else if (i < NREGS && CAP[1]) begin : g_rw
         logic [REG_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= reg_init(i);
            else if (wr_en && wr_addr == ADDR_W'(i))
               q <= wr_data;
         end
         assign regs[i] = q;
      end else if (i < NREGS) begin : g_ro
         assign regs[i] = reg_init(i);
      end else begin : g_absent
         assign regs[i] = '0;
      end
   end

   assign rd_data     = regs[rd_addr];
   assign ctrl_q      = regs[CTRL_IDX];
   assign mac_link_up = mac_q;

   // R12: MAC link bit and PHY status link bit never disagree
   a_r12_link_mirror: assert property (@(posedge clk) disable iff (rst)
      mac_q == stat_q[SB_LINK]);

   // R3: restart drops link and clears done on the next edge
   a_r3_restart_drop: assert property (@(posedge clk) disable iff (rst)
      aneg_restart |=> !mac_link_up && !stat_q[SB_DONE]);

   // R4: expiry without a competing restart brings link and done up
   a_r4_expire_up: assert property (@(posedge clk) disable iff (rst)
      aneg_expire && !aneg_restart |=> mac_link_up && stat_q[SB_DONE]);

   // R12: external falling edge without other events drops the link
   a_r12_ext_fall: assert property (@(posedge clk) disable iff (rst)
      ext_fall && !aneg_expire |=> !mac_link_up);

endmodule

// File: rtl/mphy_cmd.sv
module mphy_cmd
   import mphy_pkg::*;
#(
   parameter int unsigned NREGS = 32,
   parameter int unsigned REG_W = 16,
   localparam int unsigned ADDR_W = AFIELD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic [REG_W-1:0]  rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [REG_W-1:0]  wr_data,
   output logic [CMD_W-1:0]  cmd_q,
   output logic              irq_q
);

   mphy_op_e         op;
   logic [1:0]       cap;
   logic             in_range;
   logic             rd_ok;
   logic             err;
   logic             ie;
   logic [CMD_W-1:0] cmd_d;
   logic             unused_cmd_bits;

   assign op       = mphy_op_e'(cmd_wdata[CMD_OP_LO +: 2]);
   assign acc_addr = cmd_wdata[CMD_ADDR_LO +: ADDR_W];
   assign wr_data  = cmd_wdata[REG_W-1:0];
   assign ie       = cmd_wdata[CMD_IE];
   assign in_range = 32'(acc_addr) < NREGS;
   assign cap      = in_range ? reg_cap(32'(acc_addr)) : 2'b00;

   assign wr_en = cmd_wr && (op == OP_WRITE) && cap[1];
   assign rd_ok = (op == OP_READ) && cap[0];
   assign err   = ((op == OP_WRITE) && !cap[1]) || ((op == OP_READ) && !cap[0]);

   assign unused_cmd_bits = ^{cmd_wdata[31:30], cmd_wdata[CMD_RDY], cmd_wdata[25:21]};

   always_comb begin
      cmd_d                         = '0;
      cmd_d[REG_W-1:0]              = rd_ok ? rd_data : cmd_wdata[REG_W-1:0];
      cmd_d[CMD_ADDR_LO +: ADDR_W]  = acc_addr;
      cmd_d[CMD_OP_LO +: 2]         = op;
      cmd_d[CMD_RDY]                = 1'b1;
      cmd_d[CMD_IE]                 = ie;
      cmd_d[CMD_ERR]                = err;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q <= '0;
         irq_q <= 1'b0;
      end else begin
         if (cmd_wr)
            cmd_q <= cmd_d;
         irq_q <= cmd_wr && ie;
      end
   end

   // R8: every command completes with ready set
   a_r8_ready: assert property (@(posedge clk) disable iff (rst)
      cmd_wr |=> cmd_q[CMD_RDY]);

   // R9: an interrupt pulse only follows an enabled command
   a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
      irq_q |-> $past(cmd_wr) && cmd_q[CMD_IE]);

   // R6: a disallowed write reports an error
   a_r6_write_err: assert property (@(posedge clk) disable iff (rst)
      cmd_wr && op == OP_WRITE && !wr_en |=> cmd_q[CMD_ERR]);

   // R7: a permitted read never reports an error
   a_r7_read_ok: assert property (@(posedge clk) disable iff (rst)
      cmd_wr && rd_ok |=> !cmd_q[CMD_ERR]);

endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
   import mphy_pkg::*;
#(
   parameter int unsigned NREGS       = 32,
   parameter int unsigned REG_W       = 16,
   parameter int unsigned ANEG_CYCLES = 50_000_000
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        link_ext_up,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_wdata,
   output logic [31:0] cmd_rdata,
   output logic        cmd_irq,
   output logic        mac_link_up,
   output logic        loopback_en,
   output logic [1:0]  speed_mode,
   output logic        full_duplex
);

   localparam int unsigned ADDR_W = AFIELD_W;

   if (REG_W != FIELD_W) begin : g_bad_width
      $error("REG_W must equal the command data field width");
   end
   if (NREGS < 2 || NREGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("NREGS must cover control and status and fit the address field");
   end
   if (ANEG_CYCLES < 1) begin : g_bad_delay
      $error("ANEG_CYCLES must be at least 1");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] acc_addr;
   logic [REG_W-1:0]  wr_data;
   logic [REG_W-1:0]  rd_data;
   logic [REG_W-1:0]  ctrl_q;
   logic              aneg_restart;
   logic              aneg_expire;
   logic              aneg_busy;
   logic              unused_ctrl;

   mphy_cmd #(.NREGS(NREGS), .REG_W(REG_W)) i_cmd (
      .clk       (clk),
      .rst       (rst),
      .cmd_wr    (cmd_wr),
      .cmd_wdata (cmd_wdata),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .acc_addr  (acc_addr),
      .wr_data   (wr_data),
      .cmd_q     (cmd_rdata),
      .irq_q     (cmd_irq)
   );

   mphy_regfile #(.NREGS(NREGS), .REG_W(REG_W)) i_regs (
      .clk          (clk),
      .rst          (rst),
      .link_ext_up  (link_ext_up),
      .wr_en        (wr_en),
      .wr_addr      (acc_addr),
      .wr_data      (wr_data),
      .rd_addr      (acc_addr),
      .rd_data      (rd_data),
      .aneg_expire  (aneg_expire),
      .aneg_restart (aneg_restart),
      .ctrl_q       (ctrl_q),
      .mac_link_up  (mac_link_up)
   );

   mphy_aneg_timer #(.ANEG_CYCLES(ANEG_CYCLES)) i_aneg (
      .clk     (clk),
      .rst     (rst),
      .restart (aneg_restart),
      .expire  (aneg_expire),
      .busy    (aneg_busy)
   );

   assign loopback_en = ctrl_q[CB_LOOP];
   assign speed_mode  = {ctrl_q[CB_SPD_HI], ctrl_q[CB_SPD_LO]};
   assign full_duplex = ctrl_q[CB_FDX];
   assign unused_ctrl = ^{ctrl_q[15], ctrl_q[12:9], ctrl_q[7], ctrl_q[5:0]};

   // R5: while a delay is running and no expiry is due, the link stays down
   a_r5_down_while_busy: assert property (@(posedge clk) disable iff (rst)
      aneg_restart |=> aneg_busy && !mac_link_up);

endmodule

// File: tb/test_mgmt_phy_regs.sv
module test_mgmt_phy_regs;

   localparam int N = 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        link_ext_up = 1'b1;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        cmd_irq;
   logic        mac_link_up;
   logic        loopback_en;
   logic [1:0]  speed_mode;
   logic        full_duplex;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // reference model state
   int unsigned mregs [32];
   logic [31:0] m_cmd;
   bit          m_irq, m_mac, m_ext;
   int          m_cnt;

   always #5 clk = ~clk;

   mgmt_phy_regs #(.ANEG_CYCLES(N)) i_mgmt_phy_regs (
      .clk(clk), .rst(rst), .link_ext_up(link_ext_up),
      .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .cmd_irq(cmd_irq), .mac_link_up(mac_link_up), .loopback_en(loopback_en),
      .speed_mode(speed_mode), .full_duplex(full_duplex)
   );

   function automatic bit can_wr(int a);
      return a == 0 || a == 4 || a == 9 || a == 16 || a == 20;
   endfunction
   function automatic bit can_rd(int a);
      return can_wr(a) || a == 1 || a == 2 || a == 3 || a == 5 || a == 10 || a == 17;
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic compare_all();
      logic [15:0] c;
      c = mregs[0][15:0];
      chk("R7 R8 cmd_rdata", cmd_rdata, m_cmd);
      chk("R9 cmd_irq", 32'(cmd_irq), 32'(m_irq));
      chk("R12 mac_link_up", 32'(mac_link_up), 32'(m_mac));
      chk("R10 loopback_en", 32'(loopback_en), 32'(c[14]));
      chk("R11 speed_mode", 32'(speed_mode), 32'({c[6], c[13]}));
      chk("R11 full_duplex", 32'(full_duplex), 32'(c[8]));
   endtask

   task automatic do_reset(bit ext);
      rst = 1'b1;
      link_ext_up = ext;
      cmd_wr = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      foreach (mregs[i]) mregs[i] = 0;
      mregs[0] = 'h1140; mregs[1] = 'h794d; mregs[2] = 'h0141; mregs[3] = 'h0cc2;
      mregs[4] = 'h0de1; mregs[5] = 'h01e0; mregs[9] = 'h0e00; mregs[10] = 'h3c00;
      mregs[16] = 'h0360; mregs[17] = 'hac00; mregs[20] = 'h0d60;
      if (!ext) mregs[1] = mregs[1] & ~32'h4;
      m_cmd = '0; m_irq = 0; m_mac = ext; m_ext = ext; m_cnt = 0;
      rst = 1'b0;
      compare_all();
   endtask

   // one clock: drive at negedge, advance the model, compare at next negedge
   task automatic step(bit wr, logic [31:0] w, bit ext);
      int a; int op; bit restart; logic [15:0] rdv; logic [31:0] nc;
      cmd_wr = wr; cmd_wdata = w; link_ext_up = ext;
      a  = int'(w[20:16]);
      op = int'(w[27:26]);
      rdv = mregs[a][15:0];
      if (ext && !m_ext) begin mregs[1] |= 32'h4; m_mac = 1; end
      else if (!ext && m_ext) begin mregs[1] &= ~32'h4; m_mac = 0; end
      if (m_cnt == 1) begin mregs[1] |= 32'h24; m_mac = 1; end
      restart = wr && op == 1 && a == 0 && w[12] && w[9];
      if (restart) begin mregs[1] &= ~32'h24; m_mac = 0; end
      m_ext = ext;
      m_cnt = restart ? N : (m_cnt > 0 ? m_cnt - 1 : 0);
      if (wr) begin
         nc = '0;
         nc[20:16] = w[20:16]; nc[27:26] = w[27:26]; nc[28] = 1; nc[29] = w[29];
         nc[15:0] = w[15:0];
         if (op == 1) begin
            if (can_wr(a)) mregs[a] = int'(w[15:0]); else nc[30] = 1;
         end else if (op == 2) begin
            if (can_rd(a)) nc[15:0] = rdv; else nc[30] = 1;
         end
         m_cmd = nc;
      end
      m_irq = wr && w[29];
      @(posedge clk); @(negedge clk);
      cmd_wr = 1'b0;
      compare_all();
   endtask

   function automatic logic [31:0] cw(int op, int a, int d, bit ie);
      return (32'(ie) << 29) | (32'(op) << 26) | (32'(a) << 16) | 32'(d & 'hffff);
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, '0, link_ext_up);
   endtask

   initial begin
      @(negedge clk);
      // R1 reset state
      do_reset(1);
      chk("R1 cmd_rdata reset", cmd_rdata, 32'h0);
      chk("R1 mac_link_up reset", 32'(mac_link_up), 1);
      step(1, cw(2, 0, 0, 0), 1);
      chk("R1 ctrl reset", cmd_rdata, 32'h18001140);
      step(1, cw(2, 1, 0, 0), 1);
      chk("R1 status reset", cmd_rdata, 32'h1801794d);
      chk("R11 speed 1000 reset", 32'(speed_mode), 32'h2);
      chk("R11 duplex reset", 32'(full_duplex), 1);

      // R3 restart with interrupt
      step(1, cw(1, 0, 'h1340, 1), 1);
      chk("R3 link dropped", 32'(mac_link_up), 0);
      chk("R9 irq pulse", 32'(cmd_irq), 1);
      chk("R8 write echo", cmd_rdata, 32'h34001340);
      step(1, cw(2, 1, 0, 0), 1);
      chk("R3 status after restart", cmd_rdata, 32'h18017949);
      chk("R9 irq one cycle", 32'(cmd_irq), 0);
      // R4 exact delay: restart at step 0; read was step 1; N-2 more idle
      idle(N - 2);
      chk("R4 not before N", 32'(mac_link_up), 0);
      idle(1);
      chk("R4 up at N", 32'(mac_link_up), 1);
      step(1, cw(2, 1, 0, 0), 1);
      chk("R4 status done", cmd_rdata, 32'h1801796d);

      // R5 reload
      step(1, cw(1, 0, 'h1340, 0), 1);
      idle(10);
      step(1, cw(1, 0, 'h1340, 0), 1);
      idle(N - 1);
      chk("R5 still down after reload", 32'(mac_link_up), 0);
      idle(1);
      chk("R5 up after reload", 32'(mac_link_up), 1);

      // R13 single bits do nothing to link
      step(1, cw(1, 0, 'h0340, 0), 1);
      step(1, cw(1, 0, 'h1140, 0), 1);
      chk("R13 link kept", 32'(mac_link_up), 1);
      step(1, cw(2, 1, 0, 0), 1);
      chk("R13 status kept", cmd_rdata, 32'h1801796d);

      // R6 write protection
      step(1, cw(1, 1, 0, 0), 1);
      chk("R6 status write error", cmd_rdata, 32'h54010000);
      step(1, cw(2, 1, 0, 0), 1);
      chk("R6 status unchanged", cmd_rdata, 32'h1801796d);
      step(1, cw(1, 7, 'hbeef, 0), 1);
      chk("R6 hole write error", cmd_rdata, 32'h5407beef);
      step(1, cw(1, 4, 'h1234, 0), 1);
      step(1, cw(2, 4, 0, 0), 1);
      chk("R6 writable stored", cmd_rdata, 32'h18041234);

      // R7 reads
      step(1, cw(2, 7, 'h55, 0), 1);
      chk("R7 unreadable error", cmd_rdata, 32'h58070055);
      step(1, cw(2, 2, 0, 0), 1);
      chk("R7 id read", cmd_rdata, 32'h18020141);
      // R8 no-access op
      step(1, cw(0, 3, 'h77, 1), 1);
      chk("R8 idle op", cmd_rdata, 32'h30030077);
      step(1, cw(3, 9, 'h1, 0), 1);
      chk("R8 spare op", cmd_rdata, 32'h1c090001);
      chk("R9 no irq", 32'(cmd_irq), 0);

      // R10 / R11 control outputs
      step(1, cw(1, 0, 'h5140, 0), 1);
      chk("R10 loopback on", 32'(loopback_en), 1);
      step(1, cw(1, 0, 'h2100, 0), 1);
      chk("R11 speed 100", 32'(speed_mode), 32'h1);
      chk("R10 loopback off", 32'(loopback_en), 0);
      step(1, cw(1, 0, 'h0000, 0), 1);
      chk("R11 speed 10", 32'(speed_mode), 32'h0);
      chk("R11 half duplex", 32'(full_duplex), 0);

      // R12 external link edges
      step(0, '0, 0);
      chk("R12 ext down", 32'(mac_link_up), 0);
      step(1, cw(2, 1, 0, 0), 0);
      chk("R12 status down", cmd_rdata, 32'h18017969);
      step(0, '0, 1);
      chk("R12 ext up", 32'(mac_link_up), 1);

      // R2 reset with link down
      do_reset(0);
      chk("R2 mac after reset", 32'(mac_link_up), 0);
      step(1, cw(2, 1, 0, 0), 0);
      chk("R2 status after reset", cmd_rdata, 32'h18017949);
      step(1, cw(1, 0, 'h1340, 0), 0);
      idle(N + 2);
      chk("R4 up from reset-down", 32'(mac_link_up), 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule